// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block generates the bit-level timing for the master side of a single-wire bus. The bus is open-drain and has an external pull-up. A controller issues one primitive at a time: a bus reset with presence detection, a one-bit write slot, or a one-bit read slot. The engine drives an active-low pull-down enable, `pull_n`. It reads the line back through a two-flop synchronizer and ends every primitive with a one-cycle `done` pulse. That pulse carries either the presence flag or the sampled bit.

All durations are counted in microseconds. A divider produces a microsecond tick from the system clock, and the divider restarts when a command is accepted. Each interval is therefore an exact number of clock cycles from acceptance. Read slots release the line after a short low pulse and sample late. The sample point, including the synchronizer delay, stays under 15 µs from the slot start. Byte assembly, command layers and error checking are the job of the logic above this block.

Top module: `swire_master`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `pull_n` is 1.
- R2: A command is accepted when `cmd_valid` is 1 and `busy` is 0. `cmd_op` 2'b00 means bus reset, 2'b01 means write the bit on `cmd_wbit`, and 2'b10 means read one bit. `busy` is 1 from the cycle after acceptance. Code 2'b11 is ignored: `busy` stays 0 and the line stays released.
- R3: A bus reset drives `pull_n` low for exactly RST_LOW_US (480) µs from acceptance, then releases it. `done` arrives RST_LOW_US + RST_WAIT_US (480 + 480) µs after acceptance.
- R4: After a bus reset, the result is 1 if, and only if, the synchronized line is low at some point from PRES_FROM_US (15) µs up to, but not including, PRES_TO_US (300) µs after the release.
- R5: A write-1 slot drives the line low for W1_LOW_US (5) µs, then releases it for the rest of the slot.
- R6: A write-0 slot drives the line low for SLOT_US (62) µs. Every slot, of any kind, then leaves the line released until `done`, which arrives SLOT_US + REC_US (62 + 3) µs after acceptance.
- R7: A read slot drives the line low for RD_LOW_US (1) µs. It returns as its result the synchronized line level captured RD_SAMPLE_US (13) µs after acceptance. A responder that holds the line low past that point reads as 0. One that releases it well before that point reads as 1.
- R8: `done` is high for exactly one cycle, in the cycle in which `busy` falls. `result` is valid with it, and a write returns the bit it wrote.
- R9: A command presented while `busy` is 1 is ignored. The running slot keeps its timing and its result, and no second operation follows.
- R10: The line is released (`pull_n` = 1) whenever `busy` is 0.
- R11: One microsecond equals CLK_PER_US clock cycles. Every interval above is counted from the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation code (reset / write / read) |
| cmd_wbit | input | 1 | Bit to send in a write slot |
| line_in | input | 1 | Bus level read back (asynchronous) |
| pull_n | output | 1 | Active-low pull-down enable for the bus |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| result | output | 1 | Presence flag or read bit, valid with `done` |

## Verification
The assertions assume that `cmd_op` is a defined two-bit value whenever `cmd_valid` is high. They also assume that `line_in` only needs to be stable for whole clock cycles, because the synchronizer absorbs its asynchrony. The bench models the responder as a pull-down that changes only at the falling clock edge. That pull-down is ANDed with `pull_n`, so the line is never driven high against the master. All commands are driven at the falling edge, and the only overlapping commands are the deliberate ones presented while `busy` is high.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } swire_op_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RST_LOW  = 2'd1,
    ST_RST_WAIT = 2'd2,
    ST_SLOT     = 2'd3
  } swire_state_e;

endpackage

// File: rtl/swire_tick.sv
module swire_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart || cnt_q == LAST) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] st_q;

  // Each stage resets to 1, the released bus level.
  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[gi] <= 1'b1;
          else        st_q[gi] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[gi] <= 1'b1;
          else        st_q[gi] <= st_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_sync = st_q[STAGES-1];
endmodule

// File: rtl/swire_seq.sv
module swire_seq
  import swire_pkg::*;
#(
  parameter int RST_LOW_US   = 480,
  parameter int RST_WAIT_US  = 480,
  parameter int PRES_FROM_US = 15,
  parameter int PRES_TO_US   = 300,
  parameter int SLOT_US      = 62,
  parameter int REC_US       = 3,
  parameter int W1_LOW_US    = 5,
  parameter int RD_LOW_US    = 1,
  parameter int RD_SAMPLE_US = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       tick,
  input  logic       line_hi,
  output logic       restart,
  output logic       busy,
  output logic       done,
  output logic       result,
  output logic       pull
);
  localparam int SLOT_TOT = SLOT_US + REC_US;
  localparam int MAX_A    = (RST_LOW_US > RST_WAIT_US) ? RST_LOW_US : RST_WAIT_US;
  localparam int MAX_US   = (MAX_A > SLOT_TOT) ? MAX_A : SLOT_TOT;
  localparam int UW       = $clog2(MAX_US + 1);

  localparam logic [UW-1:0] RST_LOW_END  = UW'(RST_LOW_US - 1);
  localparam logic [UW-1:0] RST_WAIT_END = UW'(RST_WAIT_US - 1);
  localparam logic [UW-1:0] SLOT_END     = UW'(SLOT_TOT - 1);
  localparam logic [UW-1:0] SAMPLE_AT    = UW'(RD_SAMPLE_US - 1);
  localparam logic [UW-1:0] PRES_LO      = UW'(PRES_FROM_US);
  localparam logic [UW-1:0] PRES_HI      = UW'(PRES_TO_US);
  localparam logic [UW-1:0] LEN_W1       = UW'(W1_LOW_US);
  localparam logic [UW-1:0] LEN_W0       = UW'(SLOT_US);
  localparam logic [UW-1:0] LEN_RD       = UW'(RD_LOW_US);

  swire_state_e  state_q, state_d;
  swire_op_e     op_q, op_d;
  logic [UW-1:0] us_q, us_d;
  logic          bit_q, bit_d;
  logic          pull_q, pull_d;
  logic          done_q, done_d;
  logic          accept;
  logic [UW-1:0] low_len_d;

  assign accept  = (state_q == ST_IDLE) && cmd_valid && (cmd_op != OP_NONE);
  assign restart = accept;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    us_d    = us_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          op_d    = swire_op_e'(cmd_op);
          us_d    = '0;
          bit_d   = (cmd_op == OP_WRITE) ? cmd_wbit : 1'b0;
          state_d = (cmd_op == OP_RESET) ? ST_RST_LOW : ST_SLOT;
        end
      end
      ST_RST_LOW: begin
        if (tick) begin
          if (us_q == RST_LOW_END) begin
            us_d    = '0;
            state_d = ST_RST_WAIT;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      ST_RST_WAIT: begin
        if (!line_hi && us_q >= PRES_LO && us_q < PRES_HI) bit_d = 1'b1;
        if (tick) begin
          if (us_q == RST_WAIT_END) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      ST_SLOT: begin
        if (tick) begin
          if (op_q == OP_READ && us_q == SAMPLE_AT) bit_d = line_hi;
          if (us_q == SLOT_END) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Low-phase length of the slot selected by the next state
  always_comb begin
    if (op_d == OP_READ)  low_len_d = LEN_RD;
    else if (bit_d)       low_len_d = LEN_W1;
    else                  low_len_d = LEN_W0;
  end

  always_comb begin
    pull_d = (state_d == ST_RST_LOW) ||
             ((state_d == ST_SLOT) && (us_d < low_len_d));
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      us_q    <= '0;
      bit_q   <= 1'b0;
      pull_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      us_q    <= us_d;
      bit_q   <= bit_d;
      pull_q  <= pull_d;
      done_q  <= done_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = bit_q;
  assign pull   = pull_q;
endmodule

// File: rtl/swire_master.sv
module swire_master #(
  parameter int CLK_PER_US   = 50,
  parameter int RST_LOW_US   = 480,
  parameter int RST_WAIT_US  = 480,
  parameter int PRES_FROM_US = 15,
  parameter int PRES_TO_US   = 300,
  parameter int SLOT_US      = 62,
  parameter int REC_US       = 3,
  parameter int W1_LOW_US    = 5,
  parameter int RD_LOW_US    = 1,
  parameter int RD_SAMPLE_US = 13,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       line_in,
  output logic       pull_n,
  output logic       busy,
  output logic       done,
  output logic       result
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  logic       tick, restart, line_hi, pull;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  swire_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n_int), .restart(restart), .tick(tick)
  );

  swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .d_async(line_in), .q_sync(line_hi)
  );

  swire_seq #(
    .RST_LOW_US(RST_LOW_US), .RST_WAIT_US(RST_WAIT_US),
    .PRES_FROM_US(PRES_FROM_US), .PRES_TO_US(PRES_TO_US),
    .SLOT_US(SLOT_US), .REC_US(REC_US), .W1_LOW_US(W1_LOW_US),
    .RD_LOW_US(RD_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_int), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .tick(tick), .line_hi(line_hi), .restart(restart),
    .busy(busy), .done(done), .result(result), .pull(pull)
  );

  assign pull_n = ~pull;
endmodule

// File: rtl/swire_master_chk.sv
module swire_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       pull_n
);
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r8_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op != 2'b11) |=> busy);

  a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cmd_op != 2'b11)) |=> !busy);

  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> pull_n);
endmodule

bind swire_master swire_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .pull_n(pull_n)
);

// File: tb/swire_master_test.sv
module swire_master_test;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_wbit = 1'b0;
  logic       resp_low = 1'b0;
  logic       line_in;
  logic       pull_n, busy, done, result;

  int nchk = 0;
  int nerr = 0;

  int resp_mode = 0;
  int resp_dly  = 0;
  int resp_wid  = 0;

  always #10 clk = ~clk;

  assign line_in = pull_n & ~resp_low;

  swire_master #(.CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .line_in(line_in), .pull_n(pull_n), .busy(busy),
    .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Responder: mode 1 answers the reset release, mode 2 answers a falling slot edge.
  initial begin
    logic prev;
    int   cnt;
    bit   act;
    prev = 1'b1; cnt = 0; act = 0;
    forever begin
      @(negedge clk);
      if (resp_mode == 1 && !prev && pull_n) begin act = 1; cnt = 0; end
      if (resp_mode == 2 && prev && !pull_n) begin act = 1; cnt = 0; end
      if (act) begin
        resp_low = (cnt >= resp_dly * CPU) && (cnt < (resp_dly + resp_wid) * CPU);
        cnt++;
        if (cnt > (resp_dly + resp_wid) * CPU) act = 0;
      end else begin
        resp_low = 1'b0;
      end
      prev = pull_n;
    end
  end

  task automatic run_op(input logic [1:0] op, input logic wb, input int hold,
                        input int exp_low_us, input int exp_tot_us,
                        input logic exp_res, input string req);
    int n;
    int lows;
    bit seen;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wbit = wb;
    @(negedge clk);
    n = 1; lows = 0; seen = 0;
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    if (hold > 0) begin cmd_op = 2'b10; cmd_wbit = ~wb; end
    while (!seen && n < 5000) begin
      cmd_valid = (n <= hold);
      if (!pull_n) lows++;
      if (done) seen = 1;
      else begin @(negedge clk); n++; end
    end
    cmd_valid = 1'b0;
    check(lows == exp_low_us * CPU, req, "low cycles", lows, exp_low_us * CPU);
    check(n == exp_tot_us * CPU + 1, "R11", "cycles to done", n, exp_tot_us * CPU + 1);
    check(result == exp_res, req, "result", result, exp_res);
    check(busy == 1'b0, "R8", "busy at done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done width", done, 0);
  endtask

  task automatic presence(input int dly, input int wid, input logic exp);
    resp_mode = 1; resp_dly = dly; resp_wid = wid;
    run_op(2'b00, 1'b0, 0, 480, 960, exp, "R4");
    resp_mode = 0;
  endtask

  task automatic rd(input int wid, input logic exp);
    resp_mode = 2; resp_dly = 0; resp_wid = wid;
    run_op(2'b10, 1'b0, 0, 1, 65, exp, "R7");
    resp_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(pull_n == 1'b1, "R1", "pull_n", pull_n, 1);

    // R3 and R4: reset timing and presence window sweep
    run_op(2'b00, 1'b0, 0, 480, 960, 1'b0, "R3");
    presence(30, 100, 1'b1);
    presence(60, 240, 1'b1);
    presence(295, 3, 1'b1);
    presence(5, 5, 1'b0);
    presence(320, 100, 1'b0);

    // R5, R6 write slots
    run_op(2'b01, 1'b1, 0, 5, 65, 1'b1, "R5");
    run_op(2'b01, 1'b0, 0, 62, 65, 1'b0, "R6");

    // R7 read slots with different responder hold times
    rd(0, 1'b1);
    rd(11, 1'b1);
    rd(14, 1'b0);
    rd(30, 1'b0);

    // R9 commands while busy are ignored
    run_op(2'b01, 1'b1, 20, 5, 65, 1'b1, "R9");
    begin
      bit any;
      any = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (busy || done || !pull_n) any = 1;
      end
      check(!any, "R9", "activity after ignored command", any, 0);
    end

    // R2 reserved code is ignored; R10 line stays released when idle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      bit any;
      any = 0;
      for (int i = 0; i < 10; i++) begin
        if (busy || done) any = 1;
        if (!pull_n) any = 1;
        @(negedge clk);
      end
      check(!any, "R2", "reserved code started activity", any, 0);
      check(pull_n == 1'b1, "R10", "idle pull_n", pull_n, 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule